// File: doc/BRIEF.md
# Host-to-Core Doorbell Interrupt Register

This block lets a host processor raise interrupts toward a peripheral processor core. It holds a bank of 28 doorbell bits, and each bit can only drive an output. When the host writes a 1 to a bit position, that bit becomes pending and its interrupt line toward the target core goes high. When the host writes a 0 to a bit, nothing happens. A pending bit stays set until the target core pulses the acknowledge input for that bit after it has handled the interrupt.

The host reads the same register to see which doorbells are still waiting. A read returns the pending state of each bit, not the value that was last written. A bit reads 1 while its interrupt is outstanding and 0 once it has been handled. The host write port is a plain register strobe with no back-pressure: every write is taken in the cycle it is presented. The acknowledge input is also plain, with one strobe line per bit.

Top module: `doorbell_irq_reg`

## Requirements
- R1: While `rst_n` is low, and after it rises with no other stimulus, all pending bits are 0, `irq` is all 0 and `rd_data` is 0.
- R2: A clock edge with `wr_en`=1 and `wr_data[i]`=1 (i < 28) sets pending bit i. `irq[i]` and `rd_data[i]` read 1 right after that edge.
- R3: Writing `wr_data[i]`=0 with `wr_en`=1 leaves bit i unchanged. In particular, it does not cancel a pending interrupt.
- R4: A clock edge with `ack[i]`=1, and no set of bit i in the same edge, clears bit i. `irq[i]` and `rd_data[i]` read 0 right after that edge.
- R5: If a host set and a target acknowledge hit the same bit at the same edge, the bit ends set.
- R6: `irq[i]` always equals `rd_data[i]` for i in 0..27. Both are active high, and `irq` comes straight from a register.
- R7: `rd_data[31:28]` always reads 0. Write data on bits 31:28 has no effect on any output.
- R8: When `wr_en`=0, `wr_data` is ignored. An acknowledge on a bit that is not pending leaves it at 0.
- R9: All bits are independent. Setting or clearing one bit does not change any other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, accepted every cycle it is high |
| wr_data | input | 32 | Host write data; a 1 in bits 27:0 rings that doorbell |
| rd_data | output | 32 | Pending status; bits 31:28 are always 0 |
| ack | input | 28 | Per-bit acknowledge strobes from the target core |
| irq | output | 28 | Per-bit interrupt requests toward the target core, active high |

## Verification
A host write or an acknowledge presented before clock edge k shows up on `irq` and `rd_data` just after edge k, one register stage later. A quiet cycle leaves every output unchanged. The bench changes its inputs on the falling edge. A behavioural model takes the inputs at each rising edge, and the next falling edge compares `rd_data` and `irq` with that model, so every check lands one half period after the edge that should have caused the change. Directed phases cover set/acknowledge collisions, writes of zero, writes with the strobe low, and writes to the upper bits. Each phase is tagged with the requirement it exercises.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned BELL_COUNT = 28;
  localparam int unsigned WORD_W     = 32;
endpackage

// File: rtl/doorbell_set_decode.sv
module doorbell_set_decode #(
  parameter int unsigned N_BELLS = doorbell_pkg::BELL_COUNT,
  parameter int unsigned REG_W   = doorbell_pkg::WORD_W
) (
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [N_BELLS-1:0] set_vec
);
  // Only ones in the bell field ring; zeros and the upper field do nothing.
  for (genvar g = 0; g < N_BELLS; g++) begin : g_dec
    assign set_vec[g] = wr_en & wr_data[g];
  end
endmodule

// File: rtl/doorbell_cell.sv
module doorbell_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;  // set beats acknowledge
    else if (clr_i) pend_o <= 1'b0;
  end

  p_set_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> pend_o);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(pend_o));
endmodule

// File: rtl/doorbell_status_read.sv
module doorbell_status_read #(
  parameter int unsigned N_BELLS = doorbell_pkg::BELL_COUNT,
  parameter int unsigned REG_W   = doorbell_pkg::WORD_W
) (
  input  logic [N_BELLS-1:0] pend,
  output logic [REG_W-1:0]   word
);
  localparam int unsigned PAD_W = REG_W - N_BELLS;

  assign word[N_BELLS-1:0] = pend;
  if (PAD_W > 0) begin : g_pad
    assign word[REG_W-1:N_BELLS] = '0;
  end
endmodule

// File: rtl/doorbell_irq_reg.sv
module doorbell_irq_reg #(
  parameter int unsigned N_BELLS = doorbell_pkg::BELL_COUNT,
  parameter int unsigned REG_W   = doorbell_pkg::WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [N_BELLS-1:0] ack,
  output logic [N_BELLS-1:0] irq
);
  localparam int unsigned PAD_W = REG_W - N_BELLS;

  logic [N_BELLS-1:0] set_vec;
  logic [N_BELLS-1:0] pend;

  doorbell_set_decode #(.N_BELLS(N_BELLS), .REG_W(REG_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .set_vec (set_vec)
  );

  for (genvar g = 0; g < N_BELLS; g++) begin : g_bell
    doorbell_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .clr_i  (ack[g]),
      .pend_o (pend[g])
    );
  end

  assign irq = pend;

  doorbell_status_read #(.N_BELLS(N_BELLS), .REG_W(REG_W)) u_rd (
    .pend (pend),
    .word (rd_data)
  );

  p_irq_matches_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == rd_data[N_BELLS-1:0]);
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[REG_W-1:REG_W-PAD_W] != '0)) |=> (rd_data[REG_W-1:REG_W-PAD_W] == '0));
  p_no_write_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (ack == '1)) |=> (irq == '0));
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq == '0));
endmodule

// File: tb/sim_doorbell_irq_reg.sv
module sim_doorbell_irq_reg;
  localparam int NB = 28;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic [NB-1:0] ack = '0;
  logic [RW-1:0] rd_data;
  logic [NB-1:0] irq;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";
  bit    model [NB];

  always #2 clk = ~clk;  // 250 MHz

  doorbell_irq_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ack(ack), .irq(irq)
  );

  function automatic logic [RW-1:0] model_word();
    logic [RW-1:0] w = '0;
    for (int i = 0; i < NB; i++) w[i] = model[i];
    return w;
  endfunction

  task automatic compare();
    logic [RW-1:0] exp_w = model_word();
    checks++;
    if (rd_data !== exp_w) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_w);
    end
    checks++;
    if (irq !== exp_w[NB-1:0]) begin
      fails++;
      $display("FAIL %s irq actual=%h expected=%h", tag, irq, exp_w[NB-1:0]);
    end
  endtask

  // One clock: model takes inputs at rising edge, outputs compared at falling edge.
  task automatic cyc();
    @(posedge clk);
    for (int i = 0; i < NB; i++) begin
      if (!rst_n) model[i] = 1'b0;
      else if (wr_en && wr_data[i]) model[i] = 1'b1;
      else if (ack[i]) model[i] = 1'b0;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input logic we, input logic [RW-1:0] d, input logic [NB-1:0] a);
    wr_en = we; wr_data = d; ack = a;
    cyc();
    wr_en = 1'b0; wr_data = '0; ack = '0;
  endtask

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 1'b0;
    tag = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc(); cyc();

    tag = "R2";
    drive(1'b1, 32'h0000_0001, '0);
    drive(1'b1, 32'h0800_0000, '0);
    drive(1'b1, 32'h0055_AA00, '0);

    tag = "R3";
    drive(1'b1, 32'h0000_0000, '0);
    drive(1'b1, 32'h0000_0002, '0);

    tag = "R4";
    drive(1'b0, '0, 28'h000_0001);
    drive(1'b0, '0, 28'h800_0000);

    tag = "R5";
    drive(1'b1, 32'h0000_0010, 28'h000_0010);
    drive(1'b1, 32'h0000_0020, 28'h000_0030);

    tag = "R6";
    cyc();

    tag = "R7";
    drive(1'b1, 32'hF000_0000, '0);
    drive(1'b1, 32'hF000_0100, '0);

    tag = "R8";
    drive(1'b0, 32'h0FFF_FFFF, '0);
    drive(1'b0, '0, 28'h0FF_FFFF);
    drive(1'b0, '0, 28'h0FF_FFFF);

    tag = "R9";
    drive(1'b1, 32'h0000_8000, '0);
    drive(1'b0, '0, 28'h000_4000);
    for (int k = 0; k < 40; k++)
      drive(1'b1, 32'(k * 32'h0123_4567) & 32'h0FFF_FFFF, 28'(k * 28'h0765_4321));

    tag = "R1";
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule